// File: doc/BRIEF.md
# Programmable Video Sync Pulse Generator

This block produces the master-mode sync outputs of a video encoder: an active-low horizontal sync and a shared field / vertical sync output. A line-start strobe from the line counter triggers each horizontal sync pulse. A field-start strobe, given together with the line-start of the first line of a field, arms one field-sync event. That event fires a programmable number of pixel clocks after the horizontal sync leading edge.

An 8-bit read/write timing register sets four things: the horizontal pulse width, the delay from the horizontal edge to the field edge, the alignment of horizontal sync against the pixel stream, and one 2-bit field whose meaning depends on the timing mode. In mode 1 the field output is a level that toggles once per field, and bit 4 adds a long fixed offset to its edge. In mode 2 the same output is an active-low vertical pulse whose width comes from bits [5:4]. Software writes are held in a shadow copy and applied at the next line-start, so a pulse already running keeps the width and delay it started with.

Top module: `sync_pulse_gen`

## Requirements
- R1: Timing register bits [1:0] set the horizontal sync low time: code 0 gives 1 clock, 1 gives 4, 2 gives 16 and 3 gives 128. `hsync_n` is low for exactly that many cycles per line-start.
- R2: Bits [3:2] set the delay from the `hsync_n` falling edge to the field/vertical edge: code 0 gives 0 clocks, 1 gives 4, 2 gives 8 and 3 gives 16. The field edge occurs only for a line-start that came with `field_start`.
- R3: In mode 1 (`mode2_sel`=0), `field_vsync` is a level that toggles exactly once per armed field. When bit 4 is 1, the edge is delayed by a further OFFSET_CLKS clocks. Bit 5 has no effect in this mode.
- R4: In mode 2 (`mode2_sel`=1), `field_vsync` is an active-low pulse with the R2 delay and no offset. Bits [5:4] set its width: code 0 gives 1 clock, 1 gives 4, 2 gives 16 and 3 gives 128.
- R5: Bits [7:6] (value A, 0 to 3) place the `hsync_n` falling edge 1+A clocks after the clock edge that samples `line_start`. `pix_out` is `pix_in` delayed by exactly one clock.
- R6: `reg_rdata` shows the value written by `reg_wr`/`reg_wdata` from the cycle after the write onward.
- R7: A register write takes effect at the next `line_start`. A pulse in progress keeps its width even if a write lands during it, and the following line uses the new value.
- R8: After reset, `reg_rdata` is 0x00 and `hsync_n` is high. `field_vsync` is low in mode 1 and high in mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| field_start | input | 1 | One-cycle strobe with the first line-start of a field |
| mode2_sel | input | 1 | 0: timing mode 1 (field level), 1: timing mode 2 (vertical pulse) |
| reg_wr | input | 1 | Timing register write strobe |
| reg_wdata | input | 8 | Timing register write data |
| reg_rdata | output | 8 | Timing register readback |
| pix_in | input | PIX_W | Pixel data in |
| pix_out | output | PIX_W | Pixel data delayed one clock |
| hsync_n | output | 1 | Horizontal sync, active low |
| field_vsync | output | 1 | Field level (mode 1) or vertical sync, active low (mode 2) |

## Verification
The hardest situation to reach is a register write that lands while a long horizontal pulse is still running. The new value must appear on readback at once, yet leave the running pulse and the field logic untouched until the next line-start. The bench creates this by starting a 128-clock pulse, writing the minimum setting ten clocks into it, and then measuring that pulse and the following line. Every one of the 256 register codes is also swept in both timing modes. For each code, the bench measures edge positions and pulse widths in clocks after the strobe and compares them with arithmetic from the decode tables. The bench uses a reduced offset so that all sweeps fit in the run.

// File: rtl/sync_timing_pkg.sv
package sync_timing_pkg;

  // Field order matches the bit layout software writes.
  typedef struct packed {
    logic [1:0] pix_adj;  // [7:6] sync-to-pixel alignment
    logic [1:0] fsel;     // [5:4] mode 1: bit 4 offset; mode 2: vertical width
    logic [1:0] fdly;     // [3:2] horizontal-to-field delay
    logic [1:0] hwid;     // [1:0] horizontal width
  } tcfg_t;

  localparam int unsigned PW_W = 8;
  localparam int unsigned DL_W = 5;

  function automatic logic [PW_W-1:0] width_of(input logic [1:0] code);
    case (code)
      2'd0:    width_of = PW_W'(1);
      2'd1:    width_of = PW_W'(4);
      2'd2:    width_of = PW_W'(16);
      default: width_of = PW_W'(128);
    endcase
  endfunction

  function automatic logic [DL_W-1:0] delay_of(input logic [1:0] code);
    case (code)
      2'd0:    delay_of = DL_W'(0);
      2'd1:    delay_of = DL_W'(4);
      2'd2:    delay_of = DL_W'(8);
      default: delay_of = DL_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/sync_cfg_reg.sv
module sync_cfg_reg
  import sync_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       commit,
  output tcfg_t      shadow,
  output tcfg_t      active
);

  tcfg_t shadow_nxt, active_nxt;

  always_comb begin
    shadow_nxt = shadow;
    active_nxt = active;
    if (wr)     shadow_nxt = tcfg_t'(wdata);
    if (commit) active_nxt = shadow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      shadow <= shadow_nxt;
      active <= active_nxt;
    end
  end

  // R6
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> shadow == $past(wdata));

  // R7
  hold_until_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active));

endmodule

// File: rtl/sync_pulse_ctr.sv
module sync_pulse_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] width,
  output logic          pulse_n
);

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (load)          cnt_nxt = width;
    else if (cnt != 0) cnt_nxt = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign pulse_n = (cnt == '0);

  // R1
  steady_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !pulse_n) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/sync_field_ctl.sv
module sync_field_ctl
  import sync_timing_pkg::*;
#(
  parameter int unsigned OFFSET_CLKS = 864
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hstart,
  input  logic  field_start,
  input  logic  mode2_sel,
  input  tcfg_t cfg,
  output logic  vs_load,
  output logic  fld
);

  localparam int unsigned DCW = $clog2(OFFSET_CLKS + 17);

  logic           pend, pend_nxt;
  logic [DCW-1:0] dcnt, dcnt_nxt;
  logic           fld_nxt;
  logic [DCW-1:0] dly_tot;
  logic           go, fire;

  assign dly_tot = DCW'(delay_of(cfg.fdly))
                 + ((!mode2_sel && cfg.fsel[0]) ? DCW'(OFFSET_CLKS) : '0);
  assign go      = hstart && pend;
  assign fire    = (go && (dly_tot == '0)) || (dcnt == DCW'(1));
  assign vs_load = fire && mode2_sel;

  always_comb begin
    pend_nxt = field_start || (pend && !hstart);
    dcnt_nxt = dcnt;
    if (go && (dly_tot != '0)) dcnt_nxt = dly_tot;
    else if (dcnt != '0)       dcnt_nxt = dcnt - DCW'(1);
    fld_nxt = (fire && !mode2_sel) ? !fld : fld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      dcnt <= '0;
      fld  <= 1'b0;
    end else begin
      pend <= pend_nxt;
      dcnt <= dcnt_nxt;
      fld  <= fld_nxt;
    end
  end

  // R3
  field_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode2_sel || !fire) |=> $stable(fld));

  // R2
  delay_runs_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && dcnt != '0) |=> (dcnt == $past(dcnt) - DCW'(1)));

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import sync_timing_pkg::*;
#(
  parameter int unsigned PIX_W       = 8,
  parameter int unsigned OFFSET_CLKS = 864
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             field_start,
  input  logic             mode2_sel,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] pix_out,
  output logic             hsync_n,
  output logic             field_vsync
);

  localparam int unsigned ADJ_TAPS = 4;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  tcfg_t shadow, active;

  sync_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_sn),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .commit (line_start),
    .shadow (shadow),
    .active (active)
  );
  assign reg_rdata = shadow;

  // Line-start alignment taps.
  logic [ADJ_TAPS-1:0] ls_d, ls_q;
  assign ls_d[0] = line_start;
  for (genvar g = 1; g < ADJ_TAPS; g++) begin : g_tap
    assign ls_d[g] = ls_q[g-1];
  end

  logic [PIX_W-1:0] pix_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ls_q  <= '0;
      pix_q <= '0;
    end else begin
      ls_q  <= ls_d;
      pix_q <= pix_in;
    end
  end
  assign pix_out = pix_q;

  logic hstart;
  assign hstart = ls_q[active.pix_adj];

  sync_pulse_ctr #(.CW(PW_W)) u_hs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .load    (hstart),
    .width   (width_of(active.hwid)),
    .pulse_n (hsync_n)
  );

  logic vs_load, fld, vsync_n;

  sync_field_ctl #(.OFFSET_CLKS(OFFSET_CLKS)) u_fld (
    .clk         (clk),
    .rst_n       (rst_sn),
    .hstart      (hstart),
    .field_start (field_start),
    .mode2_sel   (mode2_sel),
    .cfg         (active),
    .vs_load     (vs_load),
    .fld         (fld)
  );

  sync_pulse_ctr #(.CW(PW_W)) u_vs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .load    (vs_load),
    .width   (width_of(active.fsel)),
    .pulse_n (vsync_n)
  );

  assign field_vsync = mode2_sel ? vsync_n : fld;

  // R5
  hsync_lead_edge_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(hsync_n) |-> $past(hstart));

  // R5
  pix_delay_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> pix_out == $past(pix_in));

endmodule

// File: tb/test_sync_pulse_gen.sv
module test_sync_pulse_gen;

  localparam int OFF = 40;
  localparam int WIN = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0, field_start = 1'b0, mode2_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata, pix_in = '0, pix_out;
  logic       hsync_n, field_vsync;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sync_pulse_gen #(.PIX_W(8), .OFFSET_CLKS(OFF)) i_sync_pulse_gen (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_start(field_start),
    .mode2_sel(mode2_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pix_in(pix_in), .pix_out(pix_out),
    .hsync_n(hsync_n), .field_vsync(field_vsync)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wid(input int c);
    case (c) 0: return 1; 1: return 4; 2: return 16; default: return 128; endcase
  endfunction

  function automatic int dly(input int c);
    case (c) 0: return 0; 1: return 4; 2: return 8; default: return 16; endcase
  endfunction

  // Register write; ends at a negedge with reg_wr low.
  task automatic wr(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R6 readback", reg_rdata, v);
  endtask

  // Strobe then observe WIN negedges; optional write at index wr_at.
  task automatic strobe(input logic fs, input int wr_at, input logic [7:0] wv,
                        output int hf, output int hl, output int ff,
                        output int fc, output int fl);
    logic init, prev;
    init = field_vsync; prev = init;
    hf = -1; hl = 0; ff = -1; fc = 0; fl = 0;
    line_start = 1'b1; field_start = fs; pix_in = 8'h5A ^ wv;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      if (k == 0) begin
        chk("R5 pixel delay", pix_out, 8'h5A ^ wv);
        line_start = 1'b0; field_start = 1'b0; pix_in = 8'h00;
      end
      if (reg_wr) begin
        reg_wr = 1'b0;
        chk("R6 readback mid pulse", reg_rdata, wv);
      end
      if (k == wr_at) begin reg_wr = 1'b1; reg_wdata = wv; end
      if (!hsync_n) begin hl++; if (hf < 0) hf = k; end
      if (field_vsync != init && ff < 0) ff = k;
      if (field_vsync != prev) fc++;
      if (!field_vsync) fl++;
      prev = field_vsync;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hf, hl, ff, fc, fl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8 rdata", reg_rdata, 0);
    chk("R8 hsync_n", hsync_n, 1);
    chk("R8 field level mode 1", field_vsync, 0);
    mode2_sel = 1'b1; #1;
    chk("R8 vsync_n mode 2", field_vsync, 1);
    mode2_sel = 1'b0;

    // R7: write during a 128-clock pulse
    wr(8'h03);
    strobe(1'b0, 10, 8'h00, hf, hl, ff, fc, fl);
    chk("R7 pulse width kept", hl, 128);
    chk("R7 edge", hf, 1);
    chk("R7 no field edge without field_start", fc, 0);
    strobe(1'b0, -1, 8'h00, hf, hl, ff, fc, fl);
    chk("R7 next line uses new width", hl, 1);

    for (int m = 0; m < 2; m++) begin
      mode2_sel = logic'(m);
      for (int c = 0; c < 256; c++) begin
        int a, d;
        a = (c >> 6) & 3;
        d = dly((c >> 2) & 3) + ((m == 0 && ((c >> 4) & 1) == 1) ? OFF : 0);
        wr(8'(c));
        strobe(1'b1, -1, 8'(c), hf, hl, ff, fc, fl);
        chk("R5 hsync edge", hf, a + 1);
        chk("R1 hsync width", hl, wid(c & 3));
        if (m == 0) begin
          chk("R3 field edge (R2 delay)", ff, a + 1 + d);
          chk("R3 single toggle", fc, 1);
        end else begin
          chk("R4 vsync edge (R2 delay)", ff, a + 1 + d);
          chk("R4 vsync width", fl, wid((c >> 4) & 3));
          chk("R4 one pulse", fc, 2);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule